// File: doc/BRIEF.md
# Two-Region Hierarchical State Controller with History and Timeout

This block is a synchronous controller for a two-level hierarchical state machine. The main region is an OR-superstate with five basic substates, called A to E. While the superstate is active, exactly one of them is active. A second, orthogonal region runs alongside it, so the pair forms an AND-superstate: both regions are active together, or neither is. All inputs are one-cycle event strobes, sampled once per clock step. A free-running millisecond tick drives the timeout on substate B.

The superstate can be entered in two ways. A plain entry always starts in A. A history entry returns to the substate that was active at the last exit. Leaving the superstate stores the current substate in a history register. Substate B is the timed state: if the watched event does not arrive within `TIMEOUT_MS` ticks of entering B, a timeout edge moves the machine to E and raises a one-step timeout event.

Every step works in two phases. First, all next states and data values are computed from the old values. Then they are all committed at the clock edge. Conflicting transitions are resolved by a fixed priority. Two data registers, one per region, show the commit rule: a swap exchanges their contents instead of copying one value into both.

Top module: `hsm_ctrl`

## Requirements
- R1: While `inSuper` is 1, exactly one bit of `subActive` is set (bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D, bit 4 = E). While `inSuper` is 0, `subActive` is all zero.
- R2: A plain entry (`evEnter` while outside) activates A, and the second region starts in its default state X (`regionB` = 2'b01).
- R3: A history entry (`evHist` while outside) re-activates the substate that was active at the last exit, including B. The second region restarts in X.
- R4: A history entry when no exit has occurred since reset activates A.
- R5: While inside, both regions are active (`regionB` is one-hot, X = 2'b01, Y = 2'b10), and `evFlip` toggles between X and Y. On exit, `regionB` becomes 2'b00. `evFlip` has no effect while outside.
- R6: In B, the `TIMEOUT_MS`-th `msTick` after the latest entry to B moves the machine to E, provided no watch event or exit arrives in that step. Every entry to B, including a history entry, restarts the count.
- R7: `toutEv` is 1 for exactly the one cycle after the timeout step, and 0 at all other times.
- R8: Conflicts are resolved in this order. Exit beats any internal move. In B, `evWatch` beats the timeout, and the timeout beats `evNext`. When outside, `evEnter` beats `evHist`.
- R9: `evSwap` exchanges `valA` and `valB` using pre-step values. When `evLoad` arrives in the same step, `valA` takes `dataIn` and `valB` still takes the old `valA`.
- R10: Synchronous active-high `rst` places the machine outside the superstate. It clears the history-valid flag, clears `toutEv`, and sets `valA` and `valB` to zero.
- R11: `evEnter` and `evHist` are ignored while inside. `evNext`, `evWatch` and `evExit` are ignored while outside.
- R12: `evNext` advances the substate cyclically A→B→C→D→E→A. `evWatch` moves B to D and is ignored in every other substate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evEnter | input | 1 | Plain entry strobe |
| evHist | input | 1 | History entry strobe |
| evExit | input | 1 | Leave-superstate strobe |
| evNext | input | 1 | Advance-substate strobe |
| evWatch | input | 1 | Watched event for the timed substate |
| evFlip | input | 1 | Toggle strobe for the second region |
| evLoad | input | 1 | Load `dataIn` into `valA` |
| evSwap | input | 1 | Exchange `valA` and `valB` |
| msTick | input | 1 | One-cycle pulse each millisecond |
| dataIn | input | DATA_W | Load value |
| subActive | output | 5 | One-hot main-region substate |
| regionB | output | 2 | One-hot second-region state |
| inSuper | output | 1 | Superstate active |
| toutEv | output | 1 | Timeout event, one cycle |
| valA | output | DATA_W | Main-region variable |
| valB | output | DATA_W | Second-region variable |

## Verification
The bench builds the block with `TIMEOUT_MS` = 4 and `DATA_W` = 8. With the short timeout, the bench can reach the exact firing tick several times within one compact vector table. That covers firing after a plain walk into B, firing after a history re-entry into B, and a watch event or exit arriving on the very tick that would otherwise fire. The 8-bit data width is enough to tell a swapped value from a loaded one and from a duplicated one.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  localparam int NUM_SUB = 5;

  typedef enum logic [2:0] {
    SUB_A = 3'd0,
    SUB_B = 3'd1,
    SUB_C = 3'd2,
    SUB_D = 3'd3,
    SUB_E = 3'd4
  } subId_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   cntClr;
    logic   cntInc;
    logic   histSave;
    subId_t histSub;
    logic   loadA;
    logic   swapAB;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic   histValid;
    subId_t histSub;
    logic   cntDone;
  } dpStatus_t;
endpackage

// File: rtl/hsm_ctrl_dp.sv
module hsm_ctrl_dp import hsm_pkg::*; #(
  parameter int TIMEOUT_MS = 20,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] dataIn,
  output dpStatus_t         status,
  output logic [DATA_W-1:0] valA,
  output logic [DATA_W-1:0] valB
);
  localparam int CNT_W = $clog2(TIMEOUT_MS + 1);

  subId_t            histQ;
  logic              histValidQ;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] valAQ, valBQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      histQ      <= SUB_A;
      histValidQ <= 1'b0;
    end else if (strobe.histSave) begin
      histQ      <= strobe.histSub;
      histValidQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.cntClr) cntQ <= '0;
    else if (strobe.cntInc)   cntQ <= cntQ + 1'b1;
  end

  // both registers take values computed from pre-step contents
  always_ff @(posedge clk) begin
    if (rst) begin
      valAQ <= '0;
      valBQ <= '0;
    end else begin
      if (strobe.loadA)       valAQ <= dataIn;
      else if (strobe.swapAB) valAQ <= valBQ;
      if (strobe.swapAB)      valBQ <= valAQ;
    end
  end

  assign status.histValid = histValidQ;
  assign status.histSub   = histQ;
  assign status.cntDone   = (cntQ == CNT_W'(TIMEOUT_MS - 1));
  assign valA = valAQ;
  assign valB = valBQ;
endmodule

// File: rtl/hsm_ctrl_fsm.sv
module hsm_ctrl_fsm import hsm_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        evEnter,
  input  logic        evHist,
  input  logic        evExit,
  input  logic        evNext,
  input  logic        evWatch,
  input  logic        evFlip,
  input  logic        evLoad,
  input  logic        evSwap,
  input  logic        msTick,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        inSuper,
  output subId_t      curSub,
  output logic        regY,
  output logic        toutEv
);
  logic   inQ, regQ, toutQ;
  subId_t subQ;
  logic   inN, regN, toutN, histSaveN;
  subId_t subN;
  logic   wasB, isB;

  // phase 1+2: compute everything from old values
  always_comb begin
    inN       = inQ;
    subN      = subQ;
    regN      = regQ;
    toutN     = 1'b0;
    histSaveN = 1'b0;
    if (!inQ) begin
      if (evEnter) begin
        inN  = 1'b1;
        subN = SUB_A;
        regN = 1'b0;
      end else if (evHist) begin
        inN  = 1'b1;
        subN = status.histValid ? status.histSub : SUB_A;
        regN = 1'b0;
      end
    end else if (evExit) begin
      inN       = 1'b0;
      subN      = SUB_A;
      regN      = 1'b0;
      histSaveN = 1'b1;
    end else begin
      if (evFlip) regN = ~regQ;
      if (subQ == SUB_B && evWatch) begin
        subN = SUB_D;
      end else if (subQ == SUB_B && msTick && status.cntDone) begin
        subN  = SUB_E;
        toutN = 1'b1;
      end else if (evNext) begin
        subN = (subQ == SUB_E) ? SUB_A : subId_t'(subQ + 3'd1);
      end
    end
  end

  assign wasB = inQ && (subQ == SUB_B);
  assign isB  = inN && (subN == SUB_B);

  always_comb begin
    strobe.cntClr   = !isB || !wasB;
    strobe.cntInc   = isB && wasB && msTick;
    strobe.histSave = histSaveN;
    strobe.histSub  = subQ;
    strobe.loadA    = evLoad;
    strobe.swapAB   = evSwap;
  end

  // phase 3: commit
  always_ff @(posedge clk) begin
    if (rst) begin
      inQ   <= 1'b0;
      subQ  <= SUB_A;
      regQ  <= 1'b0;
      toutQ <= 1'b0;
    end else begin
      inQ   <= inN;
      subQ  <= subN;
      regQ  <= regN;
      toutQ <= toutN;
    end
  end

  assign inSuper = inQ;
  assign curSub  = subQ;
  assign regY    = regQ;
  assign toutEv  = toutQ;
endmodule

// File: rtl/hsm_ctrl.sv
module hsm_ctrl import hsm_pkg::*; #(
  parameter int TIMEOUT_MS = 20,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evEnter,
  input  logic              evHist,
  input  logic              evExit,
  input  logic              evNext,
  input  logic              evWatch,
  input  logic              evFlip,
  input  logic              evLoad,
  input  logic              evSwap,
  input  logic              msTick,
  input  logic [DATA_W-1:0] dataIn,
  output logic [4:0]        subActive,
  output logic [1:0]        regionB,
  output logic              inSuper,
  output logic              toutEv,
  output logic [DATA_W-1:0] valA,
  output logic [DATA_W-1:0] valB
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  subId_t      curSub;
  logic        regY;

  hsm_ctrl_fsm ctrl_i (
    .clk(clk), .rst(rst),
    .evEnter(evEnter), .evHist(evHist), .evExit(evExit), .evNext(evNext),
    .evWatch(evWatch), .evFlip(evFlip), .evLoad(evLoad), .evSwap(evSwap),
    .msTick(msTick), .status(status), .strobe(strobe),
    .inSuper(inSuper), .curSub(curSub), .regY(regY), .toutEv(toutEv)
  );

  hsm_ctrl_dp #(.TIMEOUT_MS(TIMEOUT_MS), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .dataIn(dataIn),
    .status(status), .valA(valA), .valB(valB)
  );

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_sub
    assign subActive[i] = inSuper && (curSub == subId_t'(i));
  end

  assign regionB = inSuper ? (regY ? 2'b10 : 2'b01) : 2'b00;
endmodule

// File: rtl/hsm_ctrl_chk.sv
module hsm_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              evExit,
  input logic              evLoad,
  input logic              evSwap,
  input logic [4:0]        subActive,
  input logic [1:0]        regionB,
  input logic              inSuper,
  input logic              toutEv,
  input logic [DATA_W-1:0] valA,
  input logic [DATA_W-1:0] valB
);
  AST_SUB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    inSuper |-> $countones(subActive) == 1); // R1
  AST_SUB_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inSuper |-> subActive == 5'b0); // R1
  AST_REGION_BOTH: assert property (@(posedge clk) disable iff (rst)
    inSuper |-> $countones(regionB) == 1); // R5
  AST_TOUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    toutEv |=> !toutEv); // R7
  AST_TOUT_EDGE: assert property (@(posedge clk) disable iff (rst)
    toutEv |-> subActive == 5'b10000); // R6
  AST_EXIT_WINS: assert property (@(posedge clk) disable iff (rst)
    inSuper && evExit |=> !inSuper); // R8
  AST_SWAP: assert property (@(posedge clk) disable iff (rst)
    evSwap && !evLoad |=> valA == $past(valB) && valB == $past(valA)); // R9
endmodule

bind hsm_ctrl hsm_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .evExit(evExit), .evLoad(evLoad), .evSwap(evSwap),
  .subActive(subActive), .regionB(regionB), .inSuper(inSuper),
  .toutEv(toutEv), .valA(valA), .valB(valB)
);

// File: tb/hsm_ctrl_tb_top.sv
module hsm_ctrl_tb_top;
  localparam int TMO = 4;
  localparam int DW  = 8;

  // event bits
  localparam logic [6:0] EN = 7'h01, HI = 7'h02, EX = 7'h04, NX = 7'h08,
                         WA = 7'h10, FL = 7'h20, TK = 7'h40, NO = 7'h00;
  localparam logic [4:0] S0 = 5'h00, SA = 5'h01, SB = 5'h02, SC = 5'h04,
                         SD = 5'h08, SE = 5'h10;
  localparam logic [1:0] R0 = 2'b00, RX = 2'b01, RY = 2'b10;
  localparam int N = 47;

  // {events, expected subActive, expected regionB, expected toutEv}
  localparam logic [14:0] TBL [N] = '{
    {HI, SA, RX, 1'b0},      // 0  R4 history before any exit
    {NX, SB, RX, 1'b0},      // 1  R12
    {NX, SC, RX, 1'b0},      // 2  R12
    {FL, SC, RY, 1'b0},      // 3  R5
    {EX, S0, R0, 1'b0},      // 4  R1 R5 exit
    {NX, S0, R0, 1'b0},      // 5  R11 next outside ignored
    {HI, SC, RX, 1'b0},      // 6  R3 back to C
    {NX, SD, RX, 1'b0},      // 7
    {EX|NX, S0, R0, 1'b0},   // 8  R8 exit wins
    {EN, SA, RX, 1'b0},      // 9  R2 default despite history D
    {NX, SB, RX, 1'b0},      // 10
    {TK, SB, RX, 1'b0},      // 11 R6
    {TK, SB, RX, 1'b0},      // 12
    {TK, SB, RX, 1'b0},      // 13
    {TK, SE, RX, 1'b1},      // 14 R6 R7 fires
    {NO, SE, RX, 1'b0},      // 15 R7 one cycle
    {NX, SA, RX, 1'b0},      // 16 R12 wrap
    {NX, SB, RX, 1'b0},      // 17
    {TK, SB, RX, 1'b0},      // 18
    {WA, SD, RX, 1'b0},      // 19 R12 watch B->D
    {EX, S0, R0, 1'b0},      // 20
    {EN|HI, SA, RX, 1'b0},   // 21 R8 plain beats history
    {NX, SB, RX, 1'b0},      // 22
    {TK, SB, RX, 1'b0},      // 23
    {TK, SB, RX, 1'b0},      // 24
    {TK, SB, RX, 1'b0},      // 25
    {WA|TK, SD, RX, 1'b0},   // 26 R8 watch beats timeout
    {NX, SE, RX, 1'b0},      // 27
    {NX, SA, RX, 1'b0},      // 28
    {NX, SB, RX, 1'b0},      // 29
    {TK, SB, RX, 1'b0},      // 30
    {TK, SB, RX, 1'b0},      // 31
    {TK, SB, RX, 1'b0},      // 32
    {EX|TK, S0, R0, 1'b0},   // 33 R8 exit beats timeout
    {HI, SB, RX, 1'b0},      // 34 R3 history into B
    {TK, SB, RX, 1'b0},      // 35 R6 count restarted
    {TK, SB, RX, 1'b0},      // 36
    {TK, SB, RX, 1'b0},      // 37
    {TK, SE, RX, 1'b1},      // 38 R6 R7
    {FL, SE, RY, 1'b0},      // 39 R5
    {EX|FL, S0, R0, 1'b0},   // 40 R8
    {FL, S0, R0, 1'b0},      // 41 R5 flip outside ignored
    {EN, SA, RX, 1'b0},      // 42 R2
    {NX, SB, RX, 1'b0},      // 43
    {EN, SB, RX, 1'b0},      // 44 R11 entry inside ignored
    {NX, SC, RX, 1'b0},      // 45
    {WA, SC, RX, 1'b0}       // 46 R12 watch outside B ignored
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evEnter = 0, evHist = 0, evExit = 0, evNext = 0, evWatch = 0;
  logic evFlip = 0, evLoad = 0, evSwap = 0, msTick = 0;
  logic [DW-1:0] dataIn = '0;
  logic [4:0] subActive;
  logic [1:0] regionB;
  logic inSuper, toutEv;
  logic [DW-1:0] valA, valB;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hsm_ctrl #(.TIMEOUT_MS(TMO), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .evEnter(evEnter), .evHist(evHist),
    .evExit(evExit), .evNext(evNext), .evWatch(evWatch), .evFlip(evFlip),
    .evLoad(evLoad), .evSwap(evSwap), .msTick(msTick), .dataIn(dataIn),
    .subActive(subActive), .regionB(regionB), .inSuper(inSuper),
    .toutEv(toutEv), .valA(valA), .valB(valB)
  );

  task automatic step(input logic [6:0] ev, input logic ld, input logic sw,
                      input logic [DW-1:0] d);
    @(negedge clk);
    {msTick, evFlip, evWatch, evNext, evExit, evHist, evEnter} = ev;
    evLoad = ld; evSwap = sw; dataIn = d;
    @(posedge clk);
    #2;
    {msTick, evFlip, evWatch, evNext, evExit, evHist, evEnter} = '0;
    evLoad = 0; evSwap = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R10 reset state", {inSuper, subActive, regionB, toutEv, valA, valB},
        {1'b0, S0, R0, 1'b0, 8'h00, 8'h00});
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      step(TBL[i][14:8], 1'b0, 1'b0, '0);
      chk($sformatf("R1 table row %0d", i),
          {inSuper, subActive, regionB, toutEv},
          {(TBL[i][7:3] != 5'b0), TBL[i][7:0]});
    end

    // R9 load then swap, and load with swap in one step
    step(NO, 1'b1, 1'b0, 8'h5A);
    chk("R9 load", {valA, valB}, {8'h5A, 8'h00});
    step(NO, 1'b0, 1'b1, 8'h00);
    chk("R9 swap", {valA, valB}, {8'h00, 8'h5A});
    step(NO, 1'b0, 1'b1, 8'h00);
    chk("R9 swap back", {valA, valB}, {8'h5A, 8'h00});
    step(NO, 1'b1, 1'b1, 8'h33);
    chk("R9 load with swap", {valA, valB}, {8'h33, 8'h5A});

    // R10 reset mid-run clears history validity
    step(EX, 1'b0, 1'b0, '0);
    step(HI, 1'b0, 1'b0, '0);
    step(NX, 1'b0, 1'b0, '0);
    step(NX, 1'b0, 1'b0, '0);
    step(EX, 1'b0, 1'b0, '0);
    chk("R3 history setup", {inSuper, subActive}, {1'b0, S0});
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #2;
    chk("R10 reset mid-run", {inSuper, subActive, toutEv, valA, valB},
        {1'b0, S0, 1'b0, 8'h00, 8'h00});
    @(negedge clk) rst = 1'b0;
    step(HI, 1'b0, 1'b0, '0);
    chk("R10 history cleared by reset", {inSuper, subActive, regionB},
        {1'b1, SA, RX});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule